// File: doc/BRIEF.md
# Conditional-Write Register Bank with Exception Status

This block is a byte-wide register file on a simple control bus. It holds a parameterised set of configuration registers, a mode register, a compare register, an exception status register and an exception mask register. Some configuration registers are marked conditional. A write to one of them behaves as a compare-and-swap. The new byte is stored only if the register's current contents equal the compare register. Every conditional write records whether it was refused in a sticky inhibit flag.

The bank also watches for three faults and records each as an exception flag. The first is a bad-parity write on the control bus. The second is an access to a register that is absent or currently blocked. The third is a parity fault on an 8-bit upstream PHY request input. The flags for these faults, after masking, are ORed into one summary output that feeds an interrupt controller. The inhibit flag is never part of that summary.

A command is a one-cycle pulse on `bus_sel`, and `bus_wr` gives its direction. Read data is registered and appears in the cycle after the command. Address map (6-bit): mode 0x00, configuration registers from 0x10 upward, compare 0x20, exception status 0x2C, exception mask 0x2D.

Top module: `cwreg_bank`

## Requirements
- R1: After reset, every register reads 0x00, `bus_rdata` is 0x00 and `exc_summary` is 0.
- R2: A legal, parity-clean write to a plain configuration register always stores the data. A write to a conditional register (default: indices 2 and 3, addresses 0x12 and 0x13) stores the data only when the register's current value equals the compare register at 0x20. Otherwise the register keeps its previous value.
- R3: Status bit 7 (inhibit) is set after a conditional write that was refused and cleared after one that was accepted. Other writes, including software writes to the status register, leave it unchanged.
- R4: `exc_summary` is the OR of status bits 0, 5 and 6, each gated by the inverse of the same bit of the mask register at 0x2D. Bit 7 never contributes.
- R5: When mode bit 0 is 1, a write whose 8 data bits plus `bus_wpar` have even parity is discarded and sets status bits 5 and 6. When mode bit 0 is 0, parity is ignored and the write takes effect.
- R6: When mode bit 1 is 1, a `phy_valid` cycle whose 8 data bits plus `phy_par` have even parity sets status bit 0. When mode bit 1 is 0, it does not.
- R7: An access to an unmapped address, or to configuration register i while `reg_access[i]` is 0, is illegal. An illegal read returns 0x00, an illegal write changes no register, and both set status bit 6.
- R8: Status bits 0, 5 and 6 are cleared by writing 1 to them, and a fault event in the same cycle wins over the clear. Status bits 1 to 4 always read 0.
- R9: Read data appears on `bus_rdata` in the cycle after a read command and holds until the next read command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Command strobe, one cycle per command |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (6) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Odd parity bit for `bus_wdata` |
| bus_rdata | output | 8 | Registered read data |
| reg_access | input | NCFG (4) | Per-configuration-register accessibility |
| phy_valid | input | 1 | PHY request data valid |
| phy_data | input | 8 | PHY request data |
| phy_par | input | 1 | Odd parity bit for `phy_data` |
| exc_summary | output | 1 | Masked exception summary |

## Verification
Two situations are hard to reach from the ports. The first is a refused conditional write, which needs the compare register to be out of step with a target that has already been written. The bench first loads the target through an accepted conditional write, then issues a second write against the stale compare value. It then realigns the compare register to show that the inhibit flag clears again. The second is a software clear that collides with a new PHY parity fault in the same cycle. The bench drives the status write and the bad PHY byte in the same cycle and checks that the flag survives.

// File: rtl/cwreg_bank.sv
module cwreg_bank #(
  parameter int AW = 6,
  parameter int NCFG = 4,
  parameter logic [NCFG-1:0] COND_MASK = 4'b1100,
  parameter int MODE_ADDR = 'h00,
  parameter int CFG_BASE = 'h10,
  parameter int CMP_ADDR = 'h20,
  parameter int ESR_ADDR = 'h2C,
  parameter int EMR_ADDR = 'h2D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_wpar,
  output logic [7:0]      bus_rdata,
  input  logic [NCFG-1:0] reg_access,
  input  logic            phy_valid,
  input  logic [7:0]      phy_data,
  input  logic            phy_par,
  output logic            exc_summary
);
  localparam int IW = (NCFG > 1) ? $clog2(NCFG) : 1;
  localparam logic [AW-1:0] A_MODE = AW'(MODE_ADDR);
  localparam logic [AW-1:0] A_CFG  = AW'(CFG_BASE);
  localparam logic [AW-1:0] A_CMP  = AW'(CMP_ADDR);
  localparam logic [AW-1:0] A_ESR  = AW'(ESR_ADDR);
  localparam logic [AW-1:0] A_EMR  = AW'(EMR_ADDR);

  logic [1:0]            mode_q;
  logic [NCFG-1:0][7:0]  cfg_q;
  logic [7:0]            cmp_q;
  logic                  ppe_q, cpe_q, cce_q, cwi_q;
  logic [2:0]            emr_q;
  logic [7:0]            rd_mux;

  wire [AW-1:0] cfg_off = bus_addr - A_CFG;
  wire          is_cfg  = cfg_off < AW'(NCFG);
  wire [IW-1:0] idx     = cfg_off[IW-1:0];
  wire hit_mode = bus_addr == A_MODE;
  wire hit_cmp  = bus_addr == A_CMP;
  wire hit_esr  = bus_addr == A_ESR;
  wire hit_emr  = bus_addr == A_EMR;
  wire legal    = hit_mode | hit_cmp | hit_esr | hit_emr | (is_cfg && reg_access[idx]);

  wire wr_cmd   = bus_sel & bus_wr;
  wire rd_cmd   = bus_sel & ~bus_wr;
  wire par_rej  = wr_cmd & mode_q[0] & ~(^{bus_wdata, bus_wpar});
  wire wr_ok    = wr_cmd & legal & ~par_rej;
  wire cond_wr  = wr_ok & is_cfg & COND_MASK[idx];
  wire cmp_eq   = cfg_q[idx] == cmp_q;
  wire phy_bad  = phy_valid & mode_q[1] & ~(^{phy_data, phy_par});
  wire cce_ev   = (bus_sel & ~legal) | par_rej;
  wire clr      = wr_ok & hit_esr;

  assign exc_summary = |({cce_q, cpe_q, ppe_q} & ~emr_q);

  always_comb begin
    rd_mux = 8'h00;
    if (hit_mode)     rd_mux = {6'b0, mode_q};
    else if (hit_cmp) rd_mux = cmp_q;
    else if (hit_esr) rd_mux = {cwi_q, cce_q, cpe_q, 4'b0, ppe_q};
    else if (hit_emr) rd_mux = {1'b0, emr_q[2], emr_q[1], 4'b0, emr_q[0]};
    else if (is_cfg)  rd_mux = cfg_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; cmp_q <= '0; emr_q <= '0; cfg_q <= '0; bus_rdata <= '0;
      ppe_q <= 1'b0; cpe_q <= 1'b0; cce_q <= 1'b0; cwi_q <= 1'b0;
    end else begin
      if (rd_cmd) bus_rdata <= legal ? rd_mux : 8'h00;
      if (wr_ok && hit_mode) mode_q <= bus_wdata[1:0];
      if (wr_ok && hit_cmp)  cmp_q <= bus_wdata;
      if (wr_ok && hit_emr)  emr_q <= {bus_wdata[6], bus_wdata[5], bus_wdata[0]};
      if (wr_ok && is_cfg && (!COND_MASK[idx] || cmp_eq)) cfg_q[idx] <= bus_wdata;
      if (cond_wr) cwi_q <= ~cmp_eq;
      ppe_q <= phy_bad | (ppe_q & ~(clr & bus_wdata[0]));
      cpe_q <= par_rej | (cpe_q & ~(clr & bus_wdata[5]));
      cce_q <= cce_ev  | (cce_q & ~(clr & bus_wdata[6]));
    end
  end

  p_inhibit_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wr && !cmp_eq) |=> $stable(cfg_q));
  p_cwi_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wr && !cmp_eq) |=> cwi_q);
  p_cwi_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wr && cmp_eq) |=> !cwi_q);
  p_cwi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_wr |=> $stable(cwi_q));
  p_cwi_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cwi_q && !(ppe_q || cpe_q || cce_q)) |-> !exc_summary);
  p_parity_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_rej |=> (cpe_q && cce_q && $stable(cfg_q) && $stable(cmp_q)));
  p_phy_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_bad |=> ppe_q);
  p_illegal_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !legal) |=> (bus_rdata == 8'h00 && cce_q));
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> $stable(bus_rdata));
endmodule

// File: tb/cwreg_bank_tb.sv
module cwreg_bank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_wpar = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [3:0] reg_access = 4'hF;
  logic phy_valid = 0, phy_par = 0;
  logic [7:0] phy_data = '0;
  logic exc_summary;
  int checks = 0, errors = 0;
  logic pend = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cwreg_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar), .bus_rdata(bus_rdata),
    .reg_access(reg_access), .phy_valid(phy_valid), .phy_data(phy_data), .phy_par(phy_par),
    .exc_summary(exc_summary));

  always @(posedge clk) pend <= rst_n && bus_sel && !bus_wr;

  always @(negedge clk) if (pend) begin
    logic [7:0] e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit good = 1);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    bus_wpar = good ? ~^d : ^d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic phy_bad_pulse();
    phy_valid = 1; phy_data = 8'h3C; phy_par = ^8'h3C;
    @(negedge clk); phy_valid = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(exc_summary, 1'b0, "R1 summary after reset");
    chk(bus_rdata == 8'h00, 1'b1, "R1 rdata after reset");
    rd(6'h2C, 8'h00, "R1 status reset");
    rd(6'h10, 8'h00, "R1 cfg0 reset");
    rd(6'h20, 8'h00, "R1 compare reset");
    wr(6'h00, 8'h03);
    rd(6'h00, 8'h03, "R5 mode readback");
    // R2 plain write
    wr(6'h10, 8'h5A);
    rd(6'h10, 8'h5A, "R2 plain write");
    // R2/R3 accepted conditional write
    wr(6'h12, 8'h77);
    rd(6'h12, 8'h77, "R2 cond accepted");
    rd(6'h2C, 8'h00, "R3 inhibit clear");
    // R2/R3 refused
    wr(6'h12, 8'h11);
    rd(6'h12, 8'h77, "R2 cond refused keeps value");
    rd(6'h2C, 8'h80, "R3 inhibit set");
    chk(exc_summary, 1'b0, "R4 inhibit never in summary");
    wr(6'h2C, 8'h80);
    rd(6'h2C, 8'h80, "R3 software cannot clear inhibit");
    wr(6'h10, 8'h01);
    rd(6'h2C, 8'h80, "R3 plain write leaves inhibit");
    wr(6'h20, 8'h77);
    wr(6'h12, 8'h22);
    rd(6'h12, 8'h22, "R2 cond accepted after compare update");
    rd(6'h2C, 8'h00, "R3 inhibit cleared again");
    // R5 parity reject
    wr(6'h10, 8'h33, 0);
    rd(6'h10, 8'h01, "R5 bad parity write discarded");
    rd(6'h2C, 8'h60, "R5 CPE and CCE set");
    chk(exc_summary, 1'b1, "R4 summary on unmasked flags");
    wr(6'h2D, 8'hE1 & 8'h60);
    chk(exc_summary, 1'b0, "R4 summary masked");
    rd(6'h2D, 8'h60, "R4 mask readback");
    wr(6'h2C, 8'hFF);
    rd(6'h2C, 8'h00, "R8 write-one clear and reserved read 0");
    // R5 parity disabled
    wr(6'h00, 8'h02);
    wr(6'h10, 8'h44, 0);
    rd(6'h10, 8'h44, "R5 parity ignored when disabled");
    rd(6'h2C, 8'h00, "R5 no flag when disabled");
    // R6
    phy_bad_pulse();
    rd(6'h2C, 8'h01, "R6 PHY parity flag");
    chk(exc_summary, 1'b1, "R4 PPE unmasked");
    wr(6'h2C, 8'h01);
    rd(6'h2C, 8'h00, "R8 PPE cleared");
    wr(6'h00, 8'h00);
    phy_bad_pulse();
    rd(6'h2C, 8'h00, "R6 PHY parity ignored when disabled");
    // R7 illegal
    wr(6'h11, 8'h99);
    reg_access = 4'b1101;
    wr(6'h11, 8'h12);
    rd(6'h11, 8'h00, "R7 blocked read returns 0");
    rd(6'h2C, 8'h40, "R7 CCE set");
    wr(6'h2C, 8'h40);
    rd(6'h3F, 8'h00, "R7 unmapped read returns 0");
    rd(6'h2C, 8'h40, "R7 CCE on unmapped");
    wr(6'h2C, 8'h40);
    reg_access = 4'hF;
    rd(6'h11, 8'h99, "R7 blocked write changed nothing");
    // R8 set wins over clear
    wr(6'h00, 8'h02);
    phy_valid = 1; phy_data = 8'h3C; phy_par = ^8'h3C;
    wr(6'h2C, 8'h01);
    phy_valid = 0;
    rd(6'h2C, 8'h01, "R8 event wins over clear");
    // R9 hold
    rd(6'h10, 8'h44, "R9 read data");
    @(negedge clk); @(negedge clk);
    chk(bus_rdata == 8'h44, 1'b1, "R9 rdata holds");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, 1'b1, "R9 all reads returned");
    finish_run();
  end
endmodule